// File: doc/BRIEF.md
# Immediate-Amount 32-bit Barrel Shifter

This block is the shift unit of a processor datapath. It takes a 32-bit operand, a 2-bit shift-type select and the 16-bit immediate field of the instruction, and it returns the shifted operand in the same cycle. It holds no state. The shift amount is the immediate taken modulo the data width, so only its low five bits count.

The shift types are logical right, arithmetic right and rotate right, plus a pass-through code. Because the amount is taken modulo 32, a two's-complement negative immediate used with rotate gives a left rotation by the magnitude of the immediate. For example, 0xFFF4 gives an amount of 20, and a right rotation by 20 equals a left rotation by 12. The shifter is built as five cascaded mux stages that move the data by 16, 8, 4, 2 and 1 places. Each stage is enabled by one bit of the amount.

Top module: `imm_barrel_shifter`

## Requirements
- R1: With shift type 2'b00 (logical), the output is the operand shifted right by the amount, with zeros filling the vacated upper bits. Operand 0x12345678 with immediate 0x000C gives 0x00012345.
- R2: With shift type 2'b01 (arithmetic), the output is the operand shifted right by the amount, with copies of operand bit 31 filling the vacated upper bits. Operand 0x4125C203 with immediate 0x000C gives 0x0004125C, and operand 0x80000000 with immediate 0x0004 gives 0xF8000000.
- R3: With shift type 2'b10 (rotate), bits leaving bit 0 re-enter at bit 31. The output is the operand rotated right by the amount, and the number of set bits is unchanged.
- R4: The effective amount is immediate bits [4:0]. Immediate bits [15:5] have no effect. Operand 0xFEDCBA98 rotated with immediate 0xFFF4 gives 0xCBA98FED, and a logical shift with immediate 0xFFEC gives the same result as with 0x000C.
- R5: Shift type 2'b11 returns the operand unchanged, whatever the immediate.
- R6: An effective amount of 0 returns the operand unchanged for every shift type, including immediates such as 0x0020 whose low five bits are zero.
- R7: At the largest amount, 31, the results are as follows. A logical shift of 0x80000000 gives 0x00000001. An arithmetic shift of 0x80000000 gives 0xFFFFFFFF. A rotate of 0x00000001 gives 0x00000002.
- R8: The output depends only on the present inputs and follows an input change within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | 32 | Operand to shift |
| shift_type_i | input | 2 | 00 logical, 01 arithmetic, 10 rotate, 11 pass |
| imm_i | input | 16 | Instruction immediate; amount is its value mod 32 |
| data_o | output | 32 | Shifted result |

## Verification
The bench starts with directed operands:
- A positive word under the arithmetic shift, which separates sign fill from zero fill.
- 0x80000000 under the logical and arithmetic shifts, which exposes a missing or wrong sign replication.
- A dense pattern under rotate with a negative immediate, which shows whether the wrapped bits land in the right place and whether the upper immediate bits are ignored.

Amounts 0, 31, 32 and powers of two switch the mux stages on one at a time and all together, so a stage that shifts by the wrong distance is caught. A pseudo-random sweep over every shift type is compared against a behavioural model. Changes between inputs are applied without a clock edge in between, which shows that the output does not wait for a clock.

// File: rtl/bshift_pkg.sv
package bshift_pkg;
  typedef enum logic [1:0] {
    SH_LOGIC = 2'b00,
    SH_ARITH = 2'b01,
    SH_ROT   = 2'b10,
    SH_PASS  = 2'b11
  } shift_type_e;

  typedef enum logic [1:0] {
    FILL_ZERO = 2'b00,
    FILL_SIGN = 2'b01,
    FILL_WRAP = 2'b10
  } fill_e;
endpackage

// File: rtl/bshift_ctrl.sv
module bshift_ctrl
  import bshift_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  localparam int AMT_W = $clog2(DATA_W)
) (
  input  logic [1:0]       shift_type_i,
  input  logic [IMM_W-1:0] imm_i,
  output fill_e            fill_o,
  output logic [AMT_W-1:0] amt_o
);
  logic [IMM_W-1:0] amt_mod;

  // amount is the immediate modulo the data width
  assign amt_mod = imm_i % IMM_W'(DATA_W);

  always_comb begin
    fill_o = FILL_ZERO;
    amt_o  = amt_mod[AMT_W-1:0];
    case (shift_type_e'(shift_type_i))
      SH_LOGIC: fill_o = FILL_ZERO;
      SH_ARITH: fill_o = FILL_SIGN;
      SH_ROT:   fill_o = FILL_WRAP;
      default: begin
        fill_o = FILL_ZERO;
        amt_o  = '0;       // pass: every stage off
      end
    endcase
  end

  always_comb begin
    if (shift_type_i == 2'b11)
      AST_PASS_NO_AMT: assert (amt_o == '0) else $error("pass with nonzero amount"); // R5
  end
endmodule

// File: rtl/bshift_stage.sv
module bshift_stage
  import bshift_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DIST   = 1
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic              en_i,
  input  fill_e             fill_i,
  output logic [DATA_W-1:0] data_o
);
  logic [DIST-1:0] fill_bits;

  always_comb begin
    case (fill_i)
      FILL_SIGN: fill_bits = {DIST{data_i[DATA_W-1]}};
      FILL_WRAP: fill_bits = data_i[DIST-1:0];
      default:   fill_bits = '0;
    endcase
  end

  assign data_o = en_i ? {fill_bits, data_i[DATA_W-1:DIST]} : data_i;
endmodule

// File: rtl/imm_barrel_shifter.sv
module imm_barrel_shifter
  import bshift_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  localparam int AMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [1:0]        shift_type_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [DATA_W-1:0] data_o
);
  fill_e            fill;
  logic [AMT_W-1:0] amt;
  logic [DATA_W-1:0] chain [AMT_W+1];

  bshift_ctrl #(.DATA_W(DATA_W), .IMM_W(IMM_W)) i_ctrl (
    .shift_type_i(shift_type_i),
    .imm_i       (imm_i),
    .fill_o      (fill),
    .amt_o       (amt)
  );

  assign chain[0] = data_i;

  // largest distance first
  for (genvar s = 0; s < AMT_W; s++) begin : g_stage
    localparam int BIT = AMT_W - 1 - s;
    bshift_stage #(.DATA_W(DATA_W), .DIST(1 << BIT)) i_stage (
      .data_i(chain[s]),
      .en_i  (amt[BIT]),
      .fill_i(fill),
      .data_o(chain[s+1])
    );
  end

  assign data_o = chain[AMT_W];

  always_comb begin
    if (imm_i[AMT_W-1:0] == '0)
      AST_ZERO_AMT: assert (data_o == data_i) else $error("zero amount changed data"); // R6
    if (shift_type_i == 2'b11)
      AST_PASS: assert (data_o == data_i) else $error("pass changed data"); // R5
    if (shift_type_i == 2'b00 && imm_i[AMT_W-1:0] != '0)
      AST_ZERO_FILL: assert ((data_o >> (DATA_W - int'(imm_i[AMT_W-1:0]))) == '0)
        else $error("logical fill not zero"); // R1
    if (shift_type_i == 2'b01)
      AST_SIGN_KEPT: assert (data_o[DATA_W-1] == data_i[DATA_W-1]) else $error("sign lost"); // R2
    if (shift_type_i == 2'b10)
      AST_ROT_ONES: assert ($countones(data_o) == $countones(data_i)) else $error("rotate lost bits"); // R3
  end
endmodule

// File: tb/test_imm_barrel_shifter.sv
module test_imm_barrel_shifter;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] data_i = '0;
  logic [1:0]  shift_type_i = '0;
  logic [15:0] imm_i = '0;
  logic [31:0] data_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  imm_barrel_shifter i_imm_barrel_shifter (
    .data_i      (data_i),
    .shift_type_i(shift_type_i),
    .imm_i       (imm_i),
    .data_o      (data_o)
  );

  function automatic logic [31:0] model(logic [31:0] x, logic [1:0] t, logic [15:0] imm);
    int a = int'(imm[4:0]);
    case (t)
      2'b00: return x >> a;
      2'b01: return 32'($signed(x) >>> a);
      2'b10: return (a == 0) ? x : ((x >> a) | (x << (32 - a)));
      default: return x;
    endcase
  endfunction

  task automatic apply(logic [31:0] x, logic [1:0] t, logic [15:0] imm);
    data_i = x; shift_type_i = t; imm_i = imm;
    #2;
  endtask

  task automatic check(string req, logic [31:0] exp);
    n_checks++;
    if (data_o !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h (x=%08h t=%0d imm=%04h)",
               req, data_o, exp, data_i, shift_type_i, imm_i);
    end
  endtask

  task automatic run(string req, logic [31:0] x, logic [1:0] t, logic [15:0] imm, logic [31:0] exp);
    apply(x, t, imm);
    check(req, exp);
  endtask

  task automatic test_reset_state;
    run("R6", 32'h0, 2'b00, 16'h0, 32'h0);
  endtask

  task automatic test_logical;
    run("R1", 32'h12345678, 2'b00, 16'h000C, 32'h00012345);
    run("R1", 32'hFFFFFFFF, 2'b00, 16'h0004, 32'h0FFFFFFF);
  endtask

  task automatic test_arith;
    run("R2", 32'h4125C203, 2'b01, 16'h000C, 32'h0004125C);
    run("R2", 32'h80000000, 2'b01, 16'h0004, 32'hF8000000);
  endtask

  task automatic test_rotate;
    run("R3", 32'h12345678, 2'b10, 16'h0008, 32'h78123456);
    run("R3", 32'h00000001, 2'b10, 16'h0001, 32'h80000000);
  endtask

  task automatic test_imm_hi;
    run("R4", 32'hFEDCBA98, 2'b10, 16'hFFF4, 32'hCBA98FED);
    run("R4", 32'h12345678, 2'b00, 16'hFFEC, 32'h00012345);
    run("R4", 32'h80000000, 2'b01, 16'h7FE4, 32'hF8000000);
  endtask

  task automatic test_pass;
    run("R5", 32'hDEADBEEF, 2'b11, 16'h0007, 32'hDEADBEEF);
    run("R5", 32'h80000001, 2'b11, 16'hFFFF, 32'h80000001);
  endtask

  task automatic test_zero_amt;
    for (int t = 0; t < 4; t++) begin
      run("R6", 32'hA5C3F00F, 2'(t), 16'h0020, 32'hA5C3F00F);
      run("R6", 32'h8000FFFF, 2'(t), 16'h0000, 32'h8000FFFF);
    end
  endtask

  task automatic test_max_amt;
    run("R7", 32'h80000000, 2'b00, 16'h001F, 32'h00000001);
    run("R7", 32'h80000000, 2'b01, 16'h001F, 32'hFFFFFFFF);
    run("R7", 32'h00000001, 2'b10, 16'h001F, 32'h00000002);
  endtask

  task automatic test_stage_powers;
    for (int k = 0; k < 5; k++) begin
      run("R1", 32'h80000000, 2'b00, 16'(1 << k), 32'h80000000 >> (1 << k));
      run("R3", 32'h00000001, 2'b10, 16'(1 << k), model(32'h1, 2'b10, 16'(1 << k)));
    end
  endtask

  task automatic test_no_clock;
    // consecutive changes within one clock phase
    @(negedge clk);
    run("R8", 32'h0000F000, 2'b00, 16'h0004, 32'h00000F00);
    run("R8", 32'h0000F000, 2'b00, 16'h0008, 32'h000000F0);
    run("R8", 32'h0000F000, 2'b10, 16'h0010, 32'hF0000000);
  endtask

  task automatic test_sweep;
    logic [31:0] lfsr = 32'h1ACE5EED;
    for (int i = 0; i < 400; i++) begin
      logic [1:0]  t;
      logic [15:0] imm;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      t    = lfsr[1:0];
      imm  = lfsr[31:16] ^ 16'(i);
      apply(lfsr, t, imm);
      case (t)
        2'b00: check("R1", model(lfsr, t, imm));
        2'b01: check("R2", model(lfsr, t, imm));
        2'b10: check("R3", model(lfsr, t, imm));
        default: check("R5", model(lfsr, t, imm));
      endcase
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    test_reset_state();
    test_logical();
    test_arith();
    test_rotate();
    test_imm_hi();
    test_pass();
    test_zero_amt();
    test_max_amt();
    test_stage_powers();
    test_no_clock();
    test_sweep();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule